// File: doc/BRIEF.md
# Two-Channel IDE Interrupt Pending Registers

This block keeps the interrupt pending state of a two-channel IDE host controller, together with the per-channel port enables and the cable-type status. Each channel's device interrupt line and cable-detect pin pass through a synchronizer. An enabled channel latches a pending flag on each rising edge of its interrupt line. The block raises a single interrupt request towards the host while any enabled channel has a flag pending.

The host reaches the state through a byte-wide register interface with read and write strobes at fixed offsets. Software can see the pending flags in two places, and both views read the same flops. The legacy view clears a channel's flag when software reads it. The mode-register view clears a flag only when software writes a one to its bit, and the other channel's flag is left alone. The read data is combinational from the offset, so it can be sampled in the same cycle as the strobe. A read side effect takes hold at the clock edge that ends the strobe.

Top module: `ide_irq_regs`

## Requirements
- R1: After reset every register at offsets 0x50, 0x51, 0x57, 0x71 and 0x79 reads 0x00, and `irq_out` is low.
- R2: The channel 0 flag sets on a synchronized rising edge of `dev_irq[0]` while the channel 0 enable (offset 0x51 bit 2) is set, and it reads at offset 0x50 bit 2. The channel 1 flag sets the same way from `dev_irq[1]` with enable 0x51 bit 3, and it reads at offset 0x57 bit 4.
- R3: A rising edge on a disabled channel sets nothing. A level held high sets its flag only once.
- R4: A read strobe at 0x50 clears the channel 0 flag. A read strobe at 0x57 clears the channel 1 flag. Neither read touches the other channel or the 0x57 bits 3:2.
- R5: Offset 0x71 shows the channel 0 flag at bit 2 and the channel 1 flag at bit 3, and reading 0x71 clears neither flag.
- R6: Writing 0x71 with bit 2 set clears the channel 0 flag, and with bit 3 set clears the channel 1 flag. A zero written to either bit leaves that flag unchanged.
- R7: Bits 5:4 (interrupt routing) and bit 1 (memory read line enable) of 0x71 are read/write. Bits 7:6 and 0 read zero.
- R8: At 0x51, bits 3:2 are read/write and all other bits read zero. At 0x57, bits 3:2 (read-ahead disable, channel 1 devices) are read/write, and bits 7:5 and 1:0 read zero.
- R9: Offset 0x79 bit n reads the synchronized `cbl_80[n]` pin, where 1 means an 80-conductor cable. Bits 7:2 read zero, and writes to 0x79 have no effect.
- R10: When a set edge and a clear, by read or by write, reach the same flag in the same clock, the flag ends up set.
- R11: `irq_out` is high exactly when some channel has both its flag and its enable set. Clearing an enable masks the request but keeps the flag.
- R12: Writes to 0x50 and to unmapped offsets change no state. Unmapped offsets read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Register byte offset |
| reg_wr | input | 1 | Write strobe, one cycle per access |
| reg_rd | input | 1 | Read strobe, one cycle per access; triggers read-clear |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| dev_irq | input | 2 | Device interrupt lines, one per channel (asynchronous) |
| cbl_80 | input | 2 | Cable-detect pins, one per channel (asynchronous) |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The assertions assume that `reg_rd` and `reg_wr` are single-cycle strobes and that `reg_addr` and `reg_wdata` hold still while a strobe is high. The bench meets this by driving every access at the falling edge and releasing it at the next falling edge. The assertions that check a clear exclude cycles in which the synchronized rising edge fires, because the set must win in those cycles. The bench reaches the collision case on purpose. It counts the synchronizer depth and places the read or write strobe exactly in the cycle where the edge fires. Everywhere else it keeps the interrupt pulses clear of the clearing accesses.

// File: rtl/ide_irq_pkg.sv
package ide_irq_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 8;
  localparam int NUM_CH = 2;

  localparam logic [ADDR_W-1:0] OFF_CFG  = 8'h50;
  localparam logic [ADDR_W-1:0] OFF_PEN  = 8'h51;
  localparam logic [ADDR_W-1:0] OFF_CH1  = 8'h57;
  localparam logic [ADDR_W-1:0] OFF_MODE = 8'h71;
  localparam logic [ADDR_W-1:0] OFF_CBL  = 8'h79;

  localparam int CFG_PEND0_BIT  = 2;
  localparam int CH1_PEND_BIT   = 4;
  localparam int CH1_RA_LSB     = 2;
  localparam int PEN_LSB        = 2;
  localparam int MODE_PEND_LSB  = 2;
  localparam int MODE_ROUTE_LSB = 4;
  localparam int MODE_MRL_BIT   = 1;
endpackage

// File: rtl/ide_sync.sv
module ide_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage_q [STAGES];
  logic [WIDTH-1:0] stage_d [STAGES];

  always_comb begin
    stage_d[0] = din;
    for (int i = 1; i < STAGES; i++) stage_d[i] = stage_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= stage_d[i];
    end
  end

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/ide_sync_edge.sv
module ide_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic synced;
  logic prev_q;
  logic prev_d;

  ide_sync #(.STAGES(STAGES), .WIDTH(1)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (din),
    .dout (synced)
  );

  always_comb prev_d = synced;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= prev_d;
  end

  assign rise = synced & ~prev_q;
endmodule

// File: rtl/ide_pend_flag.sv
module ide_pend_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_o
);
  logic pend_q;
  logic pend_d;

  // set has priority over a clear in the same cycle
  always_comb pend_d = set_i | (pend_q & ~clr_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/ide_reg_file.sv
module ide_reg_file
  import ide_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NUM_CH-1:0] pend,
  input  logic [NUM_CH-1:0] cable,
  output logic [DATA_W-1:0] rdata,
  output logic [NUM_CH-1:0] port_en,
  output logic [NUM_CH-1:0] clr
);
  logic [NUM_CH-1:0] pen_q, pen_d;
  logic [1:0]        ra_q, ra_d;
  logic [1:0]        route_q, route_d;
  logic              mrl_q, mrl_d;

  logic wr_pen, wr_ch1, wr_mode;
  logic rd_cfg, rd_ch1;

  always_comb begin
    wr_pen  = wr && (addr == OFF_PEN);
    wr_ch1  = wr && (addr == OFF_CH1);
    wr_mode = wr && (addr == OFF_MODE);
    rd_cfg  = rd && (addr == OFF_CFG);
    rd_ch1  = rd && (addr == OFF_CH1);
  end

  // next state with explicit enables
  always_comb begin
    pen_d   = pen_q;
    ra_d    = ra_q;
    route_d = route_q;
    mrl_d   = mrl_q;
    if (wr_pen)  pen_d   = wdata[PEN_LSB +: NUM_CH];
    if (wr_ch1)  ra_d    = wdata[CH1_RA_LSB +: 2];
    if (wr_mode) begin
      route_d = wdata[MODE_ROUTE_LSB +: 2];
      mrl_d   = wdata[MODE_MRL_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pen_q   <= '0;
      ra_q    <= '0;
      route_q <= '0;
      mrl_q   <= 1'b0;
    end else begin
      pen_q   <= pen_d;
      ra_q    <= ra_d;
      route_q <= route_d;
      mrl_q   <= mrl_d;
    end
  end

  // clear strobes: legacy view clears on read, mode view on written ones
  always_comb begin
    clr[0] = rd_cfg || (wr_mode && wdata[MODE_PEND_LSB]);
    clr[1] = rd_ch1 || (wr_mode && wdata[MODE_PEND_LSB+1]);
  end

  always_comb begin
    rdata = '0;
    case (addr)
      OFF_CFG:  rdata[CFG_PEND0_BIT] = pend[0];
      OFF_PEN:  rdata[PEN_LSB +: NUM_CH] = pen_q;
      OFF_CH1: begin
        rdata[CH1_PEND_BIT]     = pend[1];
        rdata[CH1_RA_LSB +: 2]  = ra_q;
      end
      OFF_MODE: begin
        rdata[MODE_ROUTE_LSB +: 2]     = route_q;
        rdata[MODE_PEND_LSB +: NUM_CH] = pend;
        rdata[MODE_MRL_BIT]            = mrl_q;
      end
      OFF_CBL:  rdata[NUM_CH-1:0] = cable;
      default:  rdata = '0;
    endcase
  end

  assign port_en = pen_q;
endmodule

// File: rtl/ide_irq_regs.sv
module ide_irq_regs
  import ide_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [NUM_CH-1:0] dev_irq,
  input  logic [NUM_CH-1:0] cbl_80,
  output logic              irq_out
);
  logic [NUM_CH-1:0] ch_rise;
  logic [NUM_CH-1:0] ch_set;
  logic [NUM_CH-1:0] ch_clr;
  logic [NUM_CH-1:0] pend_q;
  logic [NUM_CH-1:0] port_en;
  logic [NUM_CH-1:0] cable_s;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    ide_sync_edge #(.STAGES(SYNC_STAGES)) u_edge (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (dev_irq[c]),
      .rise (ch_rise[c])
    );

    assign ch_set[c] = ch_rise[c] & port_en[c];

    ide_pend_flag u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (ch_set[c]),
      .clr_i (ch_clr[c]),
      .pend_o(pend_q[c])
    );
  end

  ide_sync #(.STAGES(SYNC_STAGES), .WIDTH(NUM_CH)) u_cbl_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (cbl_80),
    .dout (cable_s)
  );

  ide_reg_file u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .addr   (reg_addr),
    .wr     (reg_wr),
    .rd     (reg_rd),
    .wdata  (reg_wdata),
    .pend   (pend_q),
    .cable  (cable_s),
    .rdata  (reg_rdata),
    .port_en(port_en),
    .clr    (ch_clr)
  );

  assign irq_out = |(pend_q & port_en);
endmodule

// File: rtl/ide_irq_regs_chk.sv
module ide_irq_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] reg_addr,
  input logic       reg_wr,
  input logic       reg_rd,
  input logic [7:0] reg_wdata,
  input logic [1:0] dev_rise,
  input logic [1:0] port_en,
  input logic [1:0] pend,
  input logic       irq_out
);
  AST_SET_CH0: assert property (@(posedge clk) disable iff (!rst_n)
    dev_rise[0] && port_en[0] |=> pend[0]); // R10
  AST_SET_CH1: assert property (@(posedge clk) disable iff (!rst_n)
    dev_rise[1] && port_en[1] |=> pend[1]); // R2
  AST_NO_SPURIOUS_CH0: assert property (@(posedge clk) disable iff (!rst_n)
    !pend[0] && !(dev_rise[0] && port_en[0]) |=> !pend[0]); // R3
  AST_NO_SPURIOUS_CH1: assert property (@(posedge clk) disable iff (!rst_n)
    !pend[1] && !(dev_rise[1] && port_en[1]) |=> !pend[1]); // R3
  AST_RDCLR_CH0: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd && reg_addr == 8'h50 && !dev_rise[0] |=> !pend[0]); // R4
  AST_RDCLR_CH1: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd && reg_addr == 8'h57 && !dev_rise[1] |=> !pend[1]); // R4
  AST_MODE_READ_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    pend[0] && reg_rd && !reg_wr && reg_addr == 8'h71 |=> pend[0]); // R5
  AST_W1C_CH0: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_addr == 8'h71 && reg_wdata[2] && !dev_rise[0] |=> !pend[0]); // R6
  AST_W0_KEEPS_CH1: assert property (@(posedge clk) disable iff (!rst_n)
    pend[1] && reg_wr && reg_addr == 8'h71 && !reg_wdata[3]
    && !(reg_rd && reg_addr == 8'h57) |=> pend[1]); // R6
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    port_en == 2'b00 |-> !irq_out); // R11
  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (pend != 2'b00)); // R11
endmodule

bind ide_irq_regs ide_irq_regs_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .reg_addr (reg_addr),
  .reg_wr   (reg_wr),
  .reg_rd   (reg_rd),
  .reg_wdata(reg_wdata),
  .dev_rise (ch_rise),
  .port_en  (port_en),
  .pend     (pend_q),
  .irq_out  (irq_out)
);

// File: tb/ide_irq_regs_bench.sv
module ide_irq_regs_bench;
  logic       clk;
  logic       rst_n;
  logic [7:0] reg_addr;
  logic       reg_wr;
  logic       reg_rd;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic [1:0] dev_irq;
  logic [1:0] cbl_80;
  logic       irq_out;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  ide_irq_regs u_ide_irq_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_addr (reg_addr),
    .reg_wr   (reg_wr),
    .reg_rd   (reg_rd),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .dev_irq  (dev_irq),
    .cbl_80   (cbl_80),
    .irq_out  (irq_out)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic report();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic pulse(int c);
    @(negedge clk);
    dev_irq[c] = 1'b1;
    repeat (4) @(negedge clk);
    dev_irq[c] = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd_reg(8'h50, d); check("R1 cfg", d, 8'h00);
    rd_reg(8'h51, d); check("R1 pen", d, 8'h00);
    rd_reg(8'h57, d); check("R1 ch1", d, 8'h00);
    rd_reg(8'h71, d); check("R1 mode", d, 8'h00);
    rd_reg(8'h79, d); check("R1 cable", d, 8'h00);
    check("R1 irq", {7'b0, irq_out}, 8'h00);
  endtask

  task automatic t_regs_rw();
    logic [7:0] d;
    wr_reg(8'h51, 8'hFF); rd_reg(8'h51, d); check("R8 pen ones", d, 8'h0C);
    wr_reg(8'h57, 8'hFF); rd_reg(8'h57, d); check("R8 ch1 ra ones", d, 8'h0C);
    wr_reg(8'h57, 8'h04); rd_reg(8'h57, d); check("R8 ch1 ra bit2", d, 8'h04);
    wr_reg(8'h71, 8'hFF); rd_reg(8'h71, d); check("R7 mode ones", d, 8'h32);
    wr_reg(8'h71, 8'h12); rd_reg(8'h71, d); check("R7 mode mix", d, 8'h12);
    wr_reg(8'h71, 8'h00); rd_reg(8'h71, d); check("R7 mode zero", d, 8'h00);
    wr_reg(8'h57, 8'h0C);
  endtask

  task automatic t_ch0();
    logic [7:0] d;
    wr_reg(8'h51, 8'h0C);
    pulse(0);
    check("R11 irq ch0", {7'b0, irq_out}, 8'h01);
    rd_reg(8'h71, d); check("R5 mode ch0", d, 8'h04);
    rd_reg(8'h71, d); check("R5 mode reread", d, 8'h04);
    rd_reg(8'h50, d); check("R2 cfg ch0", d, 8'h04);
    rd_reg(8'h50, d); check("R4 cfg cleared", d, 8'h00);
    check("R11 irq idle", {7'b0, irq_out}, 8'h00);
  endtask

  task automatic t_ch1();
    logic [7:0] d;
    pulse(1);
    rd_reg(8'h71, d); check("R5 mode ch1", d, 8'h08);
    rd_reg(8'h57, d); check("R2 ch1 flag", d, 8'h1C);
    rd_reg(8'h57, d); check("R4 ch1 cleared ra kept", d, 8'h0C);
    pulse(0); pulse(1);
    rd_reg(8'h50, d); check("R4 cfg read", d, 8'h04);
    rd_reg(8'h71, d); check("R4 ch1 untouched", d, 8'h08);
    rd_reg(8'h57, d);
    rd_reg(8'h71, d); check("R4 both clear", d, 8'h00);
  endtask

  task automatic t_w1c();
    logic [7:0] d;
    pulse(0); pulse(1);
    wr_reg(8'h71, 8'h04); rd_reg(8'h71, d); check("R6 w1c ch0 only", d, 8'h08);
    wr_reg(8'h71, 8'h00); rd_reg(8'h71, d); check("R6 w0 keeps", d, 8'h08);
    wr_reg(8'h71, 8'h08); rd_reg(8'h71, d); check("R6 w1c ch1", d, 8'h00);
  endtask

  task automatic t_disabled();
    logic [7:0] d;
    wr_reg(8'h51, 8'h00);
    pulse(0); pulse(1);
    rd_reg(8'h71, d); check("R3 disabled edge", d, 8'h00);
    wr_reg(8'h51, 8'h04);
    @(negedge clk); dev_irq[0] = 1'b1;
    repeat (5) @(negedge clk);
    rd_reg(8'h50, d); check("R3 level first", d, 8'h04);
    repeat (6) @(negedge clk);
    rd_reg(8'h71, d); check("R3 level no retrigger", d, 8'h00);
    dev_irq[0] = 1'b0;
    repeat (4) @(negedge clk);
    wr_reg(8'h51, 8'h0C);
  endtask

  task automatic t_mask();
    logic [7:0] d;
    pulse(1);
    check("R11 irq ch1", {7'b0, irq_out}, 8'h01);
    wr_reg(8'h51, 8'h04);
    check("R11 masked", {7'b0, irq_out}, 8'h00);
    rd_reg(8'h71, d); check("R11 flag kept", d, 8'h08);
    wr_reg(8'h51, 8'h0C);
    check("R11 unmasked", {7'b0, irq_out}, 8'h01);
    wr_reg(8'h71, 8'h08);
    check("R11 cleared", {7'b0, irq_out}, 8'h00);
  endtask

  task automatic t_cable();
    logic [7:0] d;
    @(negedge clk); cbl_80 = 2'b10;
    repeat (3) @(negedge clk);
    rd_reg(8'h79, d); check("R9 cable ch1", d, 8'h02);
    @(negedge clk); cbl_80 = 2'b01;
    repeat (3) @(negedge clk);
    rd_reg(8'h79, d); check("R9 cable ch0", d, 8'h01);
    wr_reg(8'h79, 8'hFF);
    rd_reg(8'h79, d); check("R9 write ignored", d, 8'h01);
  endtask

  task automatic t_unmapped();
    logic [7:0] d;
    wr_reg(8'h60, 8'hFF); rd_reg(8'h60, d); check("R12 unmapped", d, 8'h00);
    wr_reg(8'h50, 8'hFF); rd_reg(8'h50, d); check("R12 cfg write", d, 8'h00);
    rd_reg(8'h71, d); check("R12 mode intact", d, 8'h00);
    rd_reg(8'h51, d); check("R12 pen intact", d, 8'h0C);
  endtask

  // edge fires between the 2nd and 3rd clock after the pin rises
  task automatic t_collide();
    logic [7:0] d;
    @(negedge clk); dev_irq[0] = 1'b1;
    @(negedge clk);
    @(negedge clk); reg_addr = 8'h50; reg_rd = 1'b1;
    @(negedge clk); reg_rd = 1'b0;
    rd_reg(8'h71, d); check("R10 set beats read", d, 8'h04);
    dev_irq[0] = 1'b0;
    rd_reg(8'h50, d);
    repeat (3) @(negedge clk);
    dev_irq[1] = 1'b1;
    @(negedge clk);
    @(negedge clk); reg_addr = 8'h71; reg_wdata = 8'h08; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
    rd_reg(8'h71, d); check("R10 set beats w1c", d, 8'h08);
    dev_irq[1] = 1'b0;
    wr_reg(8'h71, 8'h08);
    rd_reg(8'h71, d); check("R10 cleared after", d, 8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual=running expected=finished");
    report();
  end

  initial begin
    rst_n = 1'b0; reg_addr = '0; reg_wr = 1'b0; reg_rd = 1'b0;
    reg_wdata = '0; dev_irq = '0; cbl_80 = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regs_rw();
    t_ch0();
    t_ch1();
    t_w1c();
    t_disabled();
    t_mask();
    t_cable();
    t_unmapped();
    t_collide();
    report();
  end
endmodule